// File: doc/BRIEF.md
# Bootstrap switch control sequencer

This block decides, cycle by cycle, whether the integrated switch that tops up the floating high-side supply from the logic supply may conduct. It observes the actual states of the high-side and low-side gate outputs, the high-side and low-side commands (only their falling edges matter), and a comparator flag that is true while the floating supply node sits above 1.1 times the logic supply. Its only output is a single enable for the switch.

The enable drops in the same cycle that the high-side output is on or the node flag is true. It rises in the same cycle that the low-side output is on with the flag false. When both outputs are off (the half bridge floats), charging is allowed only inside a timed window. The rule for that window depends on which command's falling edge caused the float. After a low-side fall the window runs freely from its start. After a high-side fall the window counter is cleared on every cycle that the node flag is true. Once a window runs out, the switch stays off until the low-side output turns on again or a new command falling edge opens a fresh window.

The window length is a parameter in clock cycles. Its default of 2000 cycles gives 20 µs at 100 MHz.

Top module: `bootsw_seq`

## Requirements
- R1: While `rst_n` is low, `boot_en` is 0 whatever the other inputs are, and reset puts the sequencer in its idle (OFF) state.
- R2: `boot_en` is 0 in any cycle in which `hs_on` is 1, with no delay.
- R3: `boot_en` is 0 in any cycle in which `node_hi` is 1, with no delay. This off rule beats every on rule.
- R4: `boot_en` is 1 in any cycle with `ls_on`=1, `hs_on`=0 and `node_hi`=0, with no delay.
- R5: A falling edge of `ls_cmd` seen while both outputs are off opens a fixed window one cycle after the edge is registered. The window lasts WIN_CYCLES cycles whatever `node_hi` does, and `boot_en` equals the inverse of `node_hi` only inside it.
- R6: A falling edge of `hs_cmd` seen while both outputs are off opens a retriggerable window. Its counter is cleared on every cycle with `node_hi`=1, so the window ends only after WIN_CYCLES consecutive cycles with `node_hi`=0.
- R7: After a window runs out with both outputs off, `boot_en` stays 0, whatever `node_hi` does, until `ls_on` rises or a new command falling edge arrives.
- R8: A new command falling edge during an open window restarts the counter from 0, under the rule that belongs to the new edge's source.
- R9: When both outputs are off and no command falling edge is pending, for example when the low-side output drops with no command edge, `boot_en` stays 0.
- R10: When both commands fall in the same cycle, the high-side (retriggerable) rule is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_cmd | input | 1 | High-side command; only its falling edge is used |
| ls_cmd | input | 1 | Low-side command (true-high polarity); only its falling edge is used |
| hs_on | input | 1 | High-side gate output currently on |
| ls_on | input | 1 | Low-side gate output currently on |
| node_hi | input | 1 | Floating supply node above 1.1 times the logic supply |
| boot_en | output | 1 | Bootstrap switch enable |

## Verification
The bound checker checks on every cycle the behaviours that hold cycle by cycle:
- the immediate off rules for `hs_on` and `node_hi`, and the immediate on rule for `ls_on`;
- that the timer is cleared whenever a window opens;
- that the fixed window advances even while the node flag is high, and the retriggerable counter is cleared while it is high;
- that the counter never passes its last value;
- that the expired and idle states do not leave without a cause.

How long the windows are, taken as a whole, can only be shown by the bench's scenarios. These include:
- counting the enabled cycles after each kind of edge;
- a node flag glitch that retriggers the window;
- a restart caused by the opposite command;
- two commands falling at once.

// File: rtl/bootsw_pkg.sv
package bootsw_pkg;

  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_LOW_ON     = 3'd1,
    ST_TRI_FIXED  = 3'd2,
    ST_TRI_RETRIG = 3'd3,
    ST_EXPIRED    = 3'd4
  } bs_state_t;

  // Counter width needed to hold values 0 .. win-1.
  function automatic int unsigned win_cnt_width(input int unsigned win);
    return (win < 2) ? 1 : $clog2(win);
  endfunction

  // True when a counter value is the last cycle of a window of length win.
  function automatic logic win_is_last(input int unsigned cnt, input int unsigned win);
    return cnt == (win - 1);
  endfunction

  // A state in which the bridge floats and charging is timed.
  function automatic logic is_window(input bs_state_t st);
    return (st == ST_TRI_FIXED) || (st == ST_TRI_RETRIG);
  endfunction

endpackage

// File: rtl/bootsw_arm.sv
module bootsw_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic ls_cmd,
  input  logic consume,
  output logic arm_hs,
  output logic arm_ls
);

  logic hs_q;
  logic ls_q;
  logic hs_fall;
  logic ls_fall;
  logic arm_hs_d;
  logic arm_ls_d;

  assign hs_fall = hs_q & ~hs_cmd;
  assign ls_fall = ls_q & ~ls_cmd;

  // The newest falling edge owns the pending request. On a tie the high
  // side wins. A request is dropped when it is taken, or when its command
  // returns high.
  always_comb begin
    arm_hs_d = arm_hs;
    if (hs_fall)
      arm_hs_d = 1'b1;
    else if (ls_fall || consume || hs_cmd)
      arm_hs_d = 1'b0;

    arm_ls_d = arm_ls;
    if (ls_fall && !hs_fall)
      arm_ls_d = 1'b1;
    else if (hs_fall || consume || ls_cmd)
      arm_ls_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      arm_hs <= 1'b0;
      arm_ls <= 1'b0;
    end else begin
      hs_q   <= hs_cmd;
      ls_q   <= ls_cmd;
      arm_hs <= arm_hs_d;
      arm_ls <= arm_ls_d;
    end
  end

endmodule

// File: rtl/bootsw_timer.sv
module bootsw_timer
  import bootsw_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 2000,
  parameter int unsigned CNT_W      = win_cnt_width(WIN_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold_clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  assign done = run && !restart && !hold_clr && win_is_last(32'(cnt), WIN_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || hold_clr)
      cnt <= '0;
    else if (run && !done)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/bootsw_fsm.sv
module bootsw_fsm
  import bootsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hs_on,
  input  logic      ls_on,
  input  logic      node_hi,
  input  logic      arm_hs,
  input  logic      arm_ls,
  input  logic      tmr_done,
  output bs_state_t state,
  output logic      restart,
  output logic      run,
  output logic      hold_clr,
  output logic      boot_en
);

  bs_state_t state_d;
  logic      floating;

  assign floating = !hs_on && !ls_on;
  assign restart  = floating && (arm_hs || arm_ls);
  assign run      = is_window(state);
  assign hold_clr = (state == ST_TRI_RETRIG) && node_hi;

  // Off conditions come first. Then the low side turning on. Then a
  // pending command edge.
  assign boot_en = rst_n && !hs_on && !node_hi && (ls_on || run);

  always_comb begin
    state_d = state;
    if (ls_on)
      state_d = ST_LOW_ON;
    else if (hs_on)
      state_d = ST_OFF;
    else if (arm_hs)
      state_d = ST_TRI_RETRIG;
    else if (arm_ls)
      state_d = ST_TRI_FIXED;
    else begin
      case (state)
        ST_LOW_ON:     state_d = ST_OFF;
        ST_TRI_FIXED,
        ST_TRI_RETRIG: state_d = tmr_done ? ST_EXPIRED : state;
        default:       state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= ST_OFF;
    else
      state <= state_d;
  end

endmodule

// File: rtl/bootsw_seq.sv
module bootsw_seq
  import bootsw_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic ls_cmd,
  input  logic hs_on,
  input  logic ls_on,
  input  logic node_hi,
  output logic boot_en
);

  localparam int unsigned CNT_W = win_cnt_width(WIN_CYCLES);

  bs_state_t        state;
  logic             arm_hs;
  logic             arm_ls;
  logic             restart;
  logic             run;
  logic             hold_clr;
  logic             tmr_done;
  logic [CNT_W-1:0] cnt;

  bootsw_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_cmd  (hs_cmd),
    .ls_cmd  (ls_cmd),
    .consume (restart),
    .arm_hs  (arm_hs),
    .arm_ls  (arm_ls)
  );

  bootsw_timer #(
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .hold_clr (hold_clr),
    .run      (run),
    .cnt      (cnt),
    .done     (tmr_done)
  );

  bootsw_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_on    (hs_on),
    .ls_on    (ls_on),
    .node_hi  (node_hi),
    .arm_hs   (arm_hs),
    .arm_ls   (arm_ls),
    .tmr_done (tmr_done),
    .state    (state),
    .restart  (restart),
    .run      (run),
    .hold_clr (hold_clr),
    .boot_en  (boot_en)
  );

endmodule

// File: rtl/bootsw_chk.sv
module bootsw_chk
  import bootsw_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 2000,
  parameter int unsigned CNT_W      = win_cnt_width(WIN_CYCLES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_on,
  input logic             ls_on,
  input logic             node_hi,
  input logic             boot_en,
  input bs_state_t        state,
  input logic [CNT_W-1:0] cnt,
  input logic             restart,
  input logic             tmr_done,
  input logic             arm_hs,
  input logic             arm_ls
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  // R2
  hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> !boot_en);

  // R3
  node_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_hi |-> !boot_en);

  // R4
  low_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && !hs_on && !node_hi) |-> boot_en);

  // R5
  fixed_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRI_FIXED && !restart && !tmr_done && !ls_on && !hs_on)
      |=> (cnt == $past(cnt) + 1'b1));

  // R6
  retrig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRI_RETRIG && node_hi && !restart) |=> (cnt == '0));

  // R5 R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R7
  expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXPIRED && !ls_on && !hs_on && !arm_hs && !arm_ls)
      |=> (state == ST_EXPIRED));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && is_window(state));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && !ls_on && !arm_hs && !arm_ls) |=> (state == ST_OFF));

endmodule

bind bootsw_seq bootsw_chk #(
  .WIN_CYCLES (WIN_CYCLES),
  .CNT_W      (CNT_W)
) u_bootsw_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hs_on    (hs_on),
  .ls_on    (ls_on),
  .node_hi  (node_hi),
  .boot_en  (boot_en),
  .state    (state),
  .cnt      (cnt),
  .restart  (restart),
  .tmr_done (tmr_done),
  .arm_hs   (arm_hs),
  .arm_ls   (arm_ls)
);

// File: tb/test_bootsw_seq.sv
module test_bootsw_seq;

  localparam int WIN = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_cmd = 1'b0;
  logic ls_cmd = 1'b0;
  logic hs_on = 1'b0;
  logic ls_on = 1'b0;
  logic node_hi = 1'b0;
  logic boot_en;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bootsw_seq #(.WIN_CYCLES(WIN)) i_bootsw_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_cmd  (hs_cmd),
    .ls_cmd  (ls_cmd),
    .hs_on   (hs_on),
    .ls_on   (ls_on),
    .node_hi (node_hi),
    .boot_en (boot_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic h_on, input logic l_on, input logic h_c,
                       input logic l_c, input logic nh);
    hs_on = h_on; ls_on = l_on; hs_cmd = h_c; ls_cmd = l_c; node_hi = nh;
  endtask

  task automatic settle(input logic h_on, input logic l_on, input logic h_c,
                        input logic l_c, input logic nh);
    @(negedge clk);
    drive(h_on, l_on, h_c, l_c, nh);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #1 chk("R1 boot_en during reset", int'(boot_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R4 low side on after reset", int'(boot_en), 1);
  endtask

  task automatic t_off_rules;
    settle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 chk("R4 low side on, node low", int'(boot_en), 1);
    @(negedge clk);
    hs_on = 1'b1;
    #1 chk("R2 high side on blocks", int'(boot_en), 0);
    @(negedge clk);
    hs_on = 1'b0;
    node_hi = 1'b1;
    #1 chk("R3 node high blocks", int'(boot_en), 0);
    @(negedge clk);
    node_hi = 1'b0;
    #1 chk("R4 enable returns", int'(boot_en), 1);
  endtask

  task automatic t_fixed(input int hi_cycles, input int exp, input string tag);
    int en = 0;
    settle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, hi_cycles > 0);
    for (int i = 1; i <= WIN + 50; i++) begin
      @(negedge clk);
      node_hi = (i <= hi_cycles);
      #1 if (boot_en) en++;
    end
    chk(tag, en, exp);
    #1 chk("R7 off after fixed window", int'(boot_en), 0);
  endtask

  task automatic t_expired;
    int en = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      node_hi = i[0];
      #1 if (boot_en) en++;
    end
    chk("R7 expired ignores node flag", en, 0);
    @(negedge clk);
    node_hi = 1'b0;
    ls_on = 1'b1;
    #1 chk("R7 low side on ends expiry", int'(boot_en), 1);
  endtask

  task automatic t_retrig;
    int en = 0;
    settle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 1; i <= 560 + WIN + 50; i++) begin
      @(negedge clk);
      node_hi = (i <= 50) || (i > 550 && i <= 560);
      #1 if (boot_en) en++;
    end
    chk("R6 retriggerable window length", en, 500 + WIN);
    chk("R6 off after retriggered window", int'(boot_en), 0);
  endtask

  task automatic t_no_edge;
    int en = 0;
    settle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    ls_on = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1 if (boot_en) en++;
    end
    chk("R9 no pending edge stays off", en, 0);
  endtask

  task automatic t_restart;
    int en = 0;
    settle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 1002 + WIN + 50; i++) begin
      @(negedge clk);
      hs_cmd = (i == 1000);
      #1 if (boot_en) en++;
    end
    chk("R8 restart by high-side edge", en, 1001 + WIN);
  endtask

  task automatic t_simul;
    int en = 0;
    settle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 1; i <= 2500 + WIN + 50; i++) begin
      @(negedge clk);
      node_hi = (i <= 2500);
      #1 if (boot_en) en++;
    end
    chk("R10 simultaneous falls use retrig rule", en, WIN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_off_rules();
    t_fixed(0, WIN, "R5 fixed window length");
    t_expired();
    t_fixed(100, WIN - 99, "R5 window not extended by node high");
    t_retrig();
    t_no_edge();
    t_restart();
    t_simul();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule